// File: doc/BRIEF.md
# Write-Protect Unlock Sequencer

This block sits beside a page-write controller and inspects every host write before it reaches the storage array. It looks for two fixed address/data patterns in the write stream. A three-write pattern arms a sticky write-protect flag. A six-write pattern releases the flag. Both changes are held as pending until the programming period that follows the load session ends.

While the flag is set, the block marks as discarded any write that is not covered by the three-write prefix earlier in the same load session. Command bytes are always marked, so that the array never stores them. The page-write controller supplies two events: load-window expiry, which closes a load session, and end of programming. The controller still starts its programming timer for discarded writes. This block only decides which bytes are stored.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset, `protect_on` is 0. With `wr_stb` low, both `cmd_mark` and `discard_mark` are 0.
- R2: The writes AA@5555, 55@2AAA and A0@5555 in consecutive order each assert `cmd_mark`. `protect_on` stays unchanged until a `prog_done` pulse, and it is 1 in the cycle after that pulse, even if no data byte followed the pattern.
- R3: Address matching uses only `wr_addr[14:0]`. The values of `wr_addr[18:15]` have no effect on which writes are commands.
- R4: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 20@5555 in consecutive order each assert `cmd_mark`. `protect_on` is 0 in the cycle after the next `prog_done` pulse.
- R5: While `protect_on` is 1, a non-command write made without a completed prefix in the current session asserts `discard_mark`.
- R6: While `protect_on` is 1, data writes that follow the three-write prefix in the same session have `discard_mark` at 0 and `cmd_mark` at 0.
- R7: A write that breaks the expected pattern has `cmd_mark` at 0 and returns the detector to its first step. That write is not itself taken as a new first byte. It is discarded only if `protect_on` is 1.
- R8: A `load_expire` pulse abandons any partial pattern and ends write authorisation. After it, only an AA@5555 write can be marked as a command.
- R9: `protect_on` changes only in the cycle after a `prog_done` pulse that had a pending change. `load_expire`, and a `prog_done` with nothing pending, leave it unchanged.
- R10: Data writes that follow a completed release pattern in the same session are not discarded, even while `protect_on` is still 1.
- R11: Both marks are combinational and valid only in the cycle in which `wr_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One host write is presented in this cycle |
| wr_addr | input | AW (19) | Write address |
| wr_data | input | DW (8) | Write data byte |
| load_expire | input | 1 | Load window closed; session ends |
| prog_done | input | 1 | Programming period finished |
| protect_on | output | 1 | Sticky write-protect flag |
| cmd_mark | output | 1 | Current write is a command byte and must not be stored |
| discard_mark | output | 1 | Current write is unauthorised and must not be stored |

## Verification
Two situations are hard to reach by random traffic. The first is a completed six-write release pattern. The second is a pattern that breaks in its late steps, after an 80@5555 write has steered it toward release. Random writes almost never line up in either way. The stimulus therefore draws most writes from the command byte/address pairs, and sometimes sets random upper address bits on them. Directed runs cover a release issued while protected with data following it, and a pattern broken at its fourth step. `load_expire` and `prog_done` pulses are interleaved at random, so that pending changes sometimes land in a later session.

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int KEY_AW = 15,
  parameter logic [KEY_AW-1:0] KEY_A = 'h5555,
  parameter logic [KEY_AW-1:0] KEY_B = 'h2AAA,
  parameter logic [DW-1:0] BYTE_1 = 'hAA,
  parameter logic [DW-1:0] BYTE_2 = 'h55,
  parameter logic [DW-1:0] BYTE_LOCK = 'hA0,
  parameter logic [DW-1:0] BYTE_MID = 'h80,
  parameter logic [DW-1:0] BYTE_FREE = 'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_expire,
  input  logic          prog_done,
  output logic          protect_on,
  output logic          cmd_mark,
  output logic          discard_mark
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_D3, ST_D4, ST_D5, ST_OPEN
  } step_t;

  step_t step_q, step_nx;
  logic  prot_q, pend_set, pend_clr;
  logic  is_cmd, set_req, clr_req;

  wire at_a = (wr_addr[KEY_AW-1:0] == KEY_A);
  wire at_b = (wr_addr[KEY_AW-1:0] == KEY_B);
  wire hit1 = at_a && (wr_data == BYTE_1);
  wire hit2 = at_b && (wr_data == BYTE_2);
  wire hit_lock = at_a && (wr_data == BYTE_LOCK);
  wire hit_mid  = at_a && (wr_data == BYTE_MID);
  wire hit_free = at_a && (wr_data == BYTE_FREE);

  always_comb begin
    step_nx = ST_IDLE;
    is_cmd  = 1'b0;
    set_req = 1'b0;
    clr_req = 1'b0;
    unique case (step_q)
      ST_IDLE: if (hit1) begin step_nx = ST_K1; is_cmd = 1'b1; end
      ST_K1:   if (hit2) begin step_nx = ST_K2; is_cmd = 1'b1; end
      ST_K2: begin
        if (hit_lock) begin
          step_nx = ST_OPEN; is_cmd = 1'b1; set_req = 1'b1;
        end else if (hit_mid) begin
          step_nx = ST_D3; is_cmd = 1'b1;
        end
      end
      ST_D3:   if (hit1) begin step_nx = ST_D4; is_cmd = 1'b1; end
      ST_D4:   if (hit2) begin step_nx = ST_D5; is_cmd = 1'b1; end
      ST_D5: begin
        if (hit_free) begin
          step_nx = ST_OPEN; is_cmd = 1'b1; clr_req = 1'b1;
        end
      end
      ST_OPEN: step_nx = ST_OPEN;
      default: step_nx = ST_IDLE;
    endcase
  end

  assign cmd_mark     = wr_stb && is_cmd;
  assign discard_mark = wr_stb && !is_cmd && prot_q && (step_q != ST_OPEN);
  assign protect_on   = prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= ST_IDLE;
      prot_q   <= 1'b0;
      pend_set <= 1'b0;
      pend_clr <= 1'b0;
    end else begin
      if (load_expire)  step_q <= ST_IDLE;
      else if (wr_stb)  step_q <= step_nx;
      if (prog_done) begin
        if (pend_set) prot_q <= 1'b1;
        if (pend_clr) prot_q <= 1'b0;
        pend_set <= 1'b0;
        pend_clr <= 1'b0;
      end
      if (wr_stb && set_req) begin pend_set <= 1'b1; pend_clr <= 1'b0; end
      if (wr_stb && clr_req) begin pend_clr <= 1'b1; pend_set <= 1'b0; end
    end
  end

endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter logic [DW-1:0] BYTE_1 = 'hAA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          load_expire,
  input logic          prog_done,
  input logic          protect_on,
  input logic          cmd_mark,
  input logic          discard_mark
);

  a_r11_quiet_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> (!cmd_mark && !discard_mark));

  a_r7_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_mark && discard_mark));

  a_r5_discard_needs_protect: assert property (@(posedge clk) disable iff (!rst_n)
    discard_mark |-> protect_on);

  a_r9_protect_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_on != $past(protect_on)) |-> $past(prog_done));

  a_r8_expire_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load_expire |=> !(cmd_mark && (wr_data != BYTE_1)));

endmodule

bind wp_cmd_seq wp_cmd_seq_chk #(.AW(AW), .DW(DW), .BYTE_1(BYTE_1)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .load_expire(load_expire), .prog_done(prog_done),
  .protect_on(protect_on), .cmd_mark(cmd_mark), .discard_mark(discard_mark)
);

// File: tb/wp_cmd_seq_tb_top.sv
module wp_cmd_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic load_expire = 1'b0;
  logic prog_done = 1'b0;
  logic protect_on, cmd_mark, discard_mark;

  int total = 0;
  int bad = 0;
  int ms = 0;
  bit mp = 0, mps = 0, mpc = 0;

  always #10 clk = ~clk;

  wp_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_expire(load_expire), .prog_done(prog_done),
    .protect_on(protect_on), .cmd_mark(cmd_mark), .discard_mark(discard_mark)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic bit key_a(logic [18:0] a);
    return a[14:0] == 15'h5555;
  endfunction

  function automatic bit key_b(logic [18:0] a);
    return a[14:0] == 15'h2AAA;
  endfunction

  task automatic cyc(string tag, bit stb, logic [18:0] a, logic [7:0] d, bit ex, bit dn);
    bit e_cmd, e_disc, sreq, creq;
    int nxt;
    @(negedge clk);
    wr_stb = stb; wr_addr = a; wr_data = d; load_expire = ex; prog_done = dn;
    #2;
    e_cmd = 0; sreq = 0; creq = 0; nxt = 0;
    case (ms)
      0: if (key_a(a) && d == 8'hAA) begin e_cmd = 1; nxt = 1; end
      1: if (key_b(a) && d == 8'h55) begin e_cmd = 1; nxt = 2; end
      2: if (key_a(a) && d == 8'hA0) begin e_cmd = 1; nxt = 6; sreq = 1; end
         else if (key_a(a) && d == 8'h80) begin e_cmd = 1; nxt = 3; end
      3: if (key_a(a) && d == 8'hAA) begin e_cmd = 1; nxt = 4; end
      4: if (key_b(a) && d == 8'h55) begin e_cmd = 1; nxt = 5; end
      5: if (key_a(a) && d == 8'h20) begin e_cmd = 1; nxt = 6; creq = 1; end
      default: nxt = 6;
    endcase
    if (!stb) e_cmd = 0;
    e_disc = stb && !e_cmd && mp && (ms != 6);
    check(tag, "cmd_mark", cmd_mark, e_cmd);
    check(tag, "discard_mark", discard_mark, e_disc);
    check(tag, "protect_on", protect_on, mp);
    if (dn) begin
      if (mps) mp = 1;
      if (mpc) mp = 0;
      mps = 0; mpc = 0;
    end
    if (stb && sreq) begin mps = 1; mpc = 0; end
    if (stb && creq) begin mpc = 1; mps = 0; end
    if (ex) ms = 0;
    else if (stb) ms = nxt;
  endtask

  task automatic wr(string tag, logic [18:0] a, logic [7:0] d);
    cyc(tag, 1, a, d, 0, 0);
  endtask

  task automatic expire_done(string tag);
    cyc(tag, 0, 0, 0, 1, 0);
    cyc(tag, 0, 0, 0, 0, 1);
    cyc(tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++; bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    logic [18:0] a;
    r = $urandom(13);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check("R1", "protect_on", protect_on, 1'b0);
    check("R1", "cmd_mark", cmd_mark, 1'b0);
    check("R11", "discard_mark", discard_mark, 1'b0);

    // R7: unprotected break, data not discarded
    wr("R7", 19'h05555, 8'hAA);
    wr("R7", 19'h01234, 8'h5A);
    wr("R7", 19'h02AAA, 8'h55);
    // R2: enable pattern with no data, applied at end of programming
    wr("R2", 19'h05555, 8'hAA);
    wr("R2", 19'h02AAA, 8'h55);
    wr("R2", 19'h05555, 8'hA0);
    cyc("R2", 0, 0, 0, 1, 0);
    cyc("R2", 0, 0, 0, 0, 1);
    cyc("R2", 0, 0, 0, 0, 0);
    check("R2", "protect_on set", protect_on, 1'b1);
    // R5: protected, no prefix
    wr("R5", 19'h00010, 8'h11);
    expire_done("R9");
    check("R9", "protect_on sticky", protect_on, 1'b1);
    // R3 + R6: prefix with upper bits set, then data
    wr("R3", 19'h7D555, 8'hAA);
    wr("R3", 19'h2AAAA, 8'h55);
    wr("R3", 19'h45555, 8'hA0);
    wr("R6", 19'h00100, 8'h42);
    wr("R6", 19'h05555, 8'hAA);
    // R8: expiry ends authorisation, abandons partial pattern
    cyc("R8", 0, 0, 0, 1, 0);
    wr("R8", 19'h00101, 8'h43);
    wr("R8", 19'h05555, 8'hAA);
    wr("R8", 19'h02AAA, 8'h55);
    cyc("R8", 0, 0, 0, 1, 0);
    wr("R8", 19'h05555, 8'hA0);
    cyc("R9", 0, 0, 0, 0, 1);
    // R7: late break while protected
    wr("R7", 19'h05555, 8'hAA);
    wr("R7", 19'h02AAA, 8'h55);
    wr("R7", 19'h05555, 8'h80);
    wr("R7", 19'h02AAA, 8'h55);
    wr("R7", 19'h05555, 8'hAA);
    cyc("R7", 0, 0, 0, 1, 0);
    // R4 + R10: release pattern with data
    wr("R4", 19'h05555, 8'hAA);
    wr("R4", 19'h02AAA, 8'h55);
    wr("R4", 19'h05555, 8'h80);
    wr("R4", 19'h05555, 8'hAA);
    wr("R4", 19'h02AAA, 8'h55);
    wr("R4", 19'h05555, 8'h20);
    wr("R10", 19'h00200, 8'h99);
    wr("R10", 19'h05555, 8'hAA);
    expire_done("R4");
    check("R4", "protect_on cleared", protect_on, 1'b0);

    for (int i = 0; i < 6000; i++) begin
      r = $urandom % 16;
      a = 19'($urandom);
      case (r)
        0, 1, 2: wr("R2", 19'h05555, 8'hAA);
        3, 4:    wr("R2", 19'h02AAA, 8'h55);
        5:       wr("R2", 19'h05555, 8'hA0);
        6:       wr("R4", 19'h05555, 8'h80);
        7:       wr("R4", 19'h05555, 8'h20);
        8:       wr("R3", {a[18:15], 15'h5555}, 8'hAA);
        9:       wr("R3", {a[18:15], 15'h2AAA}, 8'h55);
        10, 11:  wr("R7", a, 8'($urandom));
        12:      cyc("R11", 0, a, 8'($urandom), 0, 0);
        13:      cyc("R8", 0, 0, 0, 1, 0);
        14:      cyc("R9", 0, 0, 0, 0, 1);
        default: cyc("R5", 1, a, 8'($urandom), 0, ($urandom % 4) == 0);
      endcase
    end
    cyc("R9", 0, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule